// File: doc/BRIEF.md
# I2C Single-Master Byte Transmitter

This block drives an I2C bus as its only master and sends data to a slave. Software controls it through two write targets: a control register and a data register. A control code prepares the block for the next bus condition. The following data-register write then carries that condition out. The block produces the clock, drives SDA, samples the slave's acknowledge, tracks whether the bus is busy and raises an interrupt request.

A write transfer runs as follows:

1. Software checks that the bus is idle and writes code E0h. This arms a start.
2. Software writes the address byte. The upper seven bits are the slave address and bit 0 is the direction, 0 for write. The block issues START and shifts the address out.
3. After each acknowledge slot, the block holds SCL low and raises the interrupt request. Each further data-register write sends one byte.
4. Software ends the transfer by writing code C0h, then any byte. That second write produces STOP and its contents never reach the bus.

The same ending is used whether the slave acknowledged or refused the last byte.

Both bus lines are open-drain. The block only ever asks for a line to be pulled low, and it reads the SDA level back.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset, neither line is pulled low, and the busy, interrupt and NACK status outputs are all 0.
- R2: While no start is armed, a data-register write on an idle bus causes no bus activity, and busy stays 0. While busy is 0, neither line is pulled low.
- R3: Control code E0h arms a start, and the bus stays untouched until the next data-register write. That write produces START (SDA falls while SCL is high) and sets busy in the same cycle. The written byte then follows.
- R4: Outside START and STOP, SDA changes only while SCL is low. Each bit lasts four quarters of QUARTER clock cycles: SCL is low for two quarters and high for two.
- R5: Bytes are sent MSB first. On the ninth clock the master leaves SDA released, and the level it samples there is latched into the NACK output (1 = NACK, 0 = ACK).
- R6: At the end of each acknowledge slot, the interrupt request rises while SCL is held low. It stays set until either the acknowledge input pulses or a control write has bit 4 set.
- R7: While SCL is held low after an acknowledge slot, each data-register write sends exactly one more byte. No START is issued.
- R8: Control code C0h, written while SCL is held after an acknowledge slot, arms a stop. The next data-register write produces STOP (SDA rises while SCL is high) in place of a byte, and its data never reaches the bus. Busy then returns to 0 with both lines released.
- R9: A byte that the slave refuses is ended by the same stop sequence, and the bus returns to idle.
- R10: Data-register writes are ignored while a start, a byte or a stop is in progress. The byte being shifted is not altered.
- R11: A control code arms a condition only when bits 7 and 6 are both set. Bit 5 chooses start (1) or stop (0). A start code is ignored unless the bus is idle, and a stop code is ignored unless SCL is held after an acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = control register, 1 = data register |
| wr_data | input | 8 | Write data |
| irq_ack | input | 1 | Interrupt acceptance, clears the request |
| sda_in | input | 1 | SDA line level read back |
| scl_low_o | output | 1 | 1 = pull SCL low, 0 = release |
| sda_low_o | output | 1 | 1 = pull SDA low, 0 = release |
| busy_o | output | 1 | Bus busy: 1 from START until STOP completes |
| nack_o | output | 1 | Last sampled acknowledge bit (1 = NACK) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench aims at these corner cases:

- **Dummy byte after a stop code.** A design that shifted this byte out would put eight extra bits on the bus where the bench's bus model expects STOP.
- **Write landing mid-byte.** A design that let this write reload the shift register would deliver a corrupted byte.
- **Misplaced control codes.** A start code written while SCL is held, or a stop code written on an idle bus, must do nothing. A design that accepted either would emit a stray START or drive the bus before any address was armed.
- **Refused byte.** The slave answers NACK, and the bench requires the NACK status to follow the line. It then requires the usual stop to bring the bus back to idle; a design that got this wrong would latch the wrong acknowledge level or hang waiting.

// File: rtl/i2ctx_pkg.sv
`timescale 1ns/1ps
package i2ctx_pkg;

    localparam int BYTE_W   = 8;
    localparam int BITCNT_W = $clog2(BYTE_W + 1);
    localparam int CODE_W   = 4;

    // Sequencer position on the bus
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_STA_A,
        SQ_STA_B,
        SQ_BIT,
        SQ_HOLD,
        SQ_STOP
    } seq_e;

    // Condition waiting for the next data-register write
    typedef enum logic [1:0] {
        ARM_NONE,
        ARM_START,
        ARM_STOP
    } arm_e;

    // Upper nibble of a control write
    typedef struct packed {
        logic master;
        logic xmit;
        logic start;
        logic irq_clr;
    } ctrl_code_t;

    // Open-drain pull requests
    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } pins_t;

    function automatic logic code_arms(input ctrl_code_t c);
        return c.master & c.xmit;
    endfunction

    function automatic logic scl_low_in_cell(input logic [1:0] quarter);
        return (quarter < 2'd2);
    endfunction

endpackage

// File: rtl/i2ctx_tick.sv
`timescale 1ns/1ps
module i2ctx_tick #(
    parameter int QUARTER = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUARTER - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/i2ctx_ctrl.sv
`timescale 1ns/1ps
module i2ctx_ctrl
    import i2ctx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  ctrl_code_t code,
    input  logic       seq_idle,
    input  logic       seq_hold,
    input  logic       arm_taken,
    input  logic       irq_set,
    input  logic       irq_ack,
    output arm_e       arm,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            arm <= ARM_NONE;
        end else if (arm_taken) begin
            arm <= ARM_NONE;
        end else if (ctrl_wr && code_arms(code)) begin
            if (code.start && seq_idle) begin
                arm <= ARM_START;
            end else if (!code.start && seq_hold) begin
                arm <= ARM_STOP;
            end
        end
    end

    // A new acknowledge event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (irq_set) begin
            irq <= 1'b1;
        end else if (irq_ack || (ctrl_wr && code.irq_clr)) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/i2ctx_seq.sv
`timescale 1ns/1ps
module i2ctx_seq
    import i2ctx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  arm_e              arm,
    input  logic              sda_in,
    output logic              run,
    output pins_t             pins,
    output logic              busy,
    output logic              nack,
    output logic              irq_set,
    output logic              arm_taken,
    output logic              seq_idle,
    output logic              seq_hold
);
    localparam logic [BITCNT_W-1:0] ACK_IDX = BITCNT_W'(BYTE_W);

    seq_e                state;
    logic [1:0]          q;
    logic [BITCNT_W-1:0] bitn;
    logic [BYTE_W-1:0]   sreg;
    logic                sda_r;
    logic                ack_slot;
    logic                start_go;
    logic                stop_go;

    assign ack_slot  = (bitn == ACK_IDX);
    assign start_go  = (state == SQ_IDLE) && data_wr && (arm == ARM_START);
    assign stop_go   = (state == SQ_HOLD) && data_wr && (arm == ARM_STOP);
    assign arm_taken = start_go || stop_go;
    assign seq_idle  = (state == SQ_IDLE);
    assign seq_hold  = (state == SQ_HOLD);
    assign run       = !(state == SQ_IDLE || state == SQ_HOLD);
    assign irq_set   = (state == SQ_BIT) && tick && (q == 2'd3) && ack_slot;

    always_comb begin
        pins.sda_low = sda_r;
        case (state)
            SQ_HOLD: pins.scl_low = 1'b1;
            SQ_BIT,
            SQ_STOP: pins.scl_low = scl_low_in_cell(q);
            default: pins.scl_low = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            q     <= 2'd0;
            bitn  <= '0;
            sreg  <= '0;
            sda_r <= 1'b0;
            busy  <= 1'b0;
            nack  <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start_go) begin
                        sreg  <= wdata;
                        q     <= 2'd0;
                        state <= SQ_STA_A;
                    end
                end
                SQ_STA_A: begin
                    if (tick) begin
                        sda_r <= 1'b1;
                        busy  <= 1'b1;
                        state <= SQ_STA_B;
                    end
                end
                SQ_STA_B: begin
                    if (tick) begin
                        if (q == 2'd1) begin
                            q     <= 2'd0;
                            bitn  <= '0;
                            state <= SQ_BIT;
                        end else begin
                            q <= q + 2'd1;
                        end
                    end
                end
                SQ_BIT: begin
                    if (tick) begin
                        q <= q + 2'd1;
                        if (q == 2'd0) begin
                            sda_r <= ack_slot ? 1'b0 : ~sreg[BYTE_W-1];
                        end
                        if (q == 2'd3) begin
                            if (ack_slot) begin
                                nack  <= sda_in;
                                state <= SQ_HOLD;
                            end else begin
                                sreg <= {sreg[BYTE_W-2:0], 1'b0};
                                bitn <= bitn + BITCNT_W'(1);
                            end
                        end
                    end
                end
                SQ_HOLD: begin
                    if (data_wr) begin
                        q <= 2'd0;
                        if (arm == ARM_STOP) begin
                            state <= SQ_STOP;
                        end else begin
                            sreg  <= wdata;
                            bitn  <= '0;
                            state <= SQ_BIT;
                        end
                    end
                end
                SQ_STOP: begin
                    if (tick) begin
                        q <= q + 2'd1;
                        if (q == 2'd0) begin
                            sda_r <= 1'b1;
                        end
                        if (q == 2'd3) begin
                            sda_r <= 1'b0;
                            busy  <= 1'b0;
                            state <= SQ_IDLE;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_tx_master.sv
`timescale 1ns/1ps
module i2c_tx_master
    import i2ctx_pkg::*;
#(
    parameter int QUARTER = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       irq_ack,
    input  logic       sda_in,
    output logic       scl_low_o,
    output logic       sda_low_o,
    output logic       busy_o,
    output logic       nack_o,
    output logic       irq_o
);
    logic       ctrl_wr;
    logic       data_wr;
    logic       run;
    logic       tick;
    logic       irq_set;
    logic       arm_taken;
    logic       seq_idle;
    logic       seq_hold;
    arm_e       arm;
    pins_t      pins;
    ctrl_code_t code;

    assign ctrl_wr = wr_en && !wr_sel;
    assign data_wr = wr_en && wr_sel;
    assign code    = ctrl_code_t'(wr_data[7:8-CODE_W]);

    i2ctx_tick #(.QUARTER(QUARTER)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    i2ctx_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .code      (code),
        .seq_idle  (seq_idle),
        .seq_hold  (seq_hold),
        .arm_taken (arm_taken),
        .irq_set   (irq_set),
        .irq_ack   (irq_ack),
        .arm       (arm),
        .irq       (irq_o)
    );

    i2ctx_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .data_wr   (data_wr),
        .wdata     (wr_data),
        .arm       (arm),
        .sda_in    (sda_in),
        .run       (run),
        .pins      (pins),
        .busy      (busy_o),
        .nack      (nack_o),
        .irq_set   (irq_set),
        .arm_taken (arm_taken),
        .seq_idle  (seq_idle),
        .seq_hold  (seq_hold)
    );

    assign scl_low_o = pins.scl_low;
    assign sda_low_o = pins.sda_low;
endmodule

// File: rtl/i2ctx_checker.sv
`timescale 1ns/1ps
module i2ctx_checker (
    input logic clk,
    input logic rst,
    input logic scl_low_o,
    input logic sda_low_o,
    input logic busy_o,
    input logic nack_o,
    input logic irq_o
);
    AST_START_MARKS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!scl_low_o && $past(!scl_low_o) && $rose(sda_low_o)) |-> $rose(busy_o)); // R3
    AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!scl_low_o && $past(!scl_low_o) && $fell(sda_low_o)) |-> $fell(busy_o)); // R8
    AST_SDA_STILL_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!scl_low_o && $past(!scl_low_o) && !$stable(sda_low_o)) |-> !$stable(busy_o)); // R4
    AST_FREE_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!scl_low_o && !sda_low_o)); // R2
    AST_IRQ_WITH_SCL_HELD: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> (scl_low_o && busy_o && !sda_low_o)); // R6
    AST_NACK_ONLY_AT_SLOT: assert property (@(posedge clk) disable iff (rst)
        !$stable(nack_o) |-> $rose(irq_o)); // R5
endmodule

bind i2c_tx_master i2ctx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_low_o (scl_low_o),
    .sda_low_o (sda_low_o),
    .busy_o    (busy_o),
    .nack_o    (nack_o),
    .irq_o     (irq_o)
);

// File: tb/i2c_tx_master_test.sv
`timescale 1ns/1ps
module i2c_tx_master_test;
    localparam int EV_START = -1;
    localparam int EV_STOP  = -2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq_ack = 1'b0;
    logic       sda_in;
    logic       scl_low_o, sda_low_o, busy_o, nack_o, irq_o;

    logic slave_pull = 1'b0;
    logic slave_nack = 1'b0;
    logic scl_line, sda_line;

    int checks = 0;
    int errors = 0;
    int events = 0;
    bit done = 1'b0;
    int exp_q[$];

    assign scl_line = ~scl_low_o;
    assign sda_line = ~(sda_low_o | slave_pull);
    assign sda_in   = sda_line;

    i2c_tx_master uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq_ack(irq_ack), .sda_in(sda_in), .scl_low_o(scl_low_o),
        .sda_low_o(sda_low_o), .busy_o(busy_o), .nack_o(nack_o), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_item(input int got, input string req);
        int want;
        events++;
        if (exp_q.size() == 0) begin
            check(1'b0, req, "unexpected bus item", got, 999);
        end else begin
            want = exp_q.pop_front();
            check(got == want, req, "bus item", got, want);
        end
    endtask

    // Bus monitor and slave model, sampled away from the active edge
    initial begin
        logic p_scl = 1'b1;
        logic p_sda = 1'b1;
        logic [7:0] sr = 8'h00;
        int bitcnt = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (scl_line && p_scl && !sda_line && p_sda) begin
                    expect_item(EV_START, "R3");
                    bitcnt = 0;
                end else if (scl_line && p_scl && sda_line && !p_sda) begin
                    expect_item(EV_STOP, "R8");
                    bitcnt = 0;
                end
                if (scl_line && !p_scl) begin
                    if (bitcnt < 8) begin
                        sr = {sr[6:0], sda_line};
                        bitcnt++;
                        if (bitcnt == 8) expect_item(int'(sr), "R5");
                    end else if (bitcnt == 8) begin
                        bitcnt = 9;
                        check(sda_low_o == 1'b0, "R5", "master released SDA in ack slot",
                              sda_low_o, 0);
                    end
                end
                if (!scl_line && p_scl) begin
                    if (bitcnt == 8) slave_pull = !slave_nack;
                    else if (bitcnt == 9) begin
                        slave_pull = 1'b0;
                        bitcnt = 0;
                    end
                end
            end
            p_scl = scl_line;
            p_sda = sda_line;
        end
    end

    task automatic reg_write(input bit sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: writes and pushes what the bus must show
    task automatic send_start(input logic [7:0] addr);
        reg_write(1'b0, 8'hE0);
        exp_q.push_back(EV_START);
        exp_q.push_back(int'(addr));
        reg_write(1'b1, addr);
    endtask

    task automatic send_byte(input logic [7:0] d);
        exp_q.push_back(int'(d));
        reg_write(1'b1, d);
    endtask

    task automatic send_stop(input logic [7:0] dummy);
        reg_write(1'b0, 8'hC0);
        exp_q.push_back(EV_STOP);
        reg_write(1'b1, dummy);
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq_o && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(irq_o == 1'b1, req, "interrupt after ack slot", irq_o, 1);
    endtask

    task automatic wait_free(input string req);
        int n = 0;
        while (busy_o && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(busy_o == 1'b0, req, "busy cleared", busy_o, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(scl_low_o == 0, "R1", "scl_low", scl_low_o, 0);
        check(sda_low_o == 0, "R1", "sda_low", sda_low_o, 0);
        check(busy_o == 0, "R1", "busy", busy_o, 0);
        check(irq_o == 0, "R1", "irq", irq_o, 0);
        check(nack_o == 0, "R1", "nack", nack_o, 0);

        // R2 data write with nothing armed; R11 stop code on idle bus
        reg_write(1'b1, 8'h5A);
        reg_write(1'b0, 8'hC0);
        reg_write(1'b1, 8'h33);
        reg_write(1'b0, 8'h60);
        reg_write(1'b1, 8'h44);
        repeat (60) @(negedge clk);
        check(busy_o == 0, "R2", "busy after unarmed writes", busy_o, 0);
        check(scl_low_o == 0 && sda_low_o == 0, "R11", "lines after misplaced codes",
              {scl_low_o, sda_low_o}, 0);
        check(events == 0, "R2", "bus items seen", events, 0);

        // R3 start armed: nothing before the data write
        reg_write(1'b0, 8'hE0);
        repeat (30) @(negedge clk);
        check(busy_o == 0 && scl_low_o == 0 && sda_low_o == 0, "R3",
              "bus idle while start armed", {busy_o, scl_low_o, sda_low_o}, 0);
        exp_q.push_back(EV_START);
        exp_q.push_back(8'hA4);
        slave_nack = 1'b0;
        reg_write(1'b1, 8'hA4);
        wait_irq("R6");
        check(busy_o == 1, "R3", "busy after start", busy_o, 1);
        check(nack_o == 0, "R5", "ack latched", nack_o, 0);
        check(scl_low_o == 1, "R6", "SCL held after slot", scl_low_o, 1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        check(irq_o == 0, "R6", "irq after acceptance", irq_o, 0);

        // R7 next byte; R10 write landing mid-byte
        send_byte(8'h3C);
        repeat (20) @(negedge clk);
        reg_write(1'b1, 8'hFF);
        wait_irq("R7");
        reg_write(1'b0, 8'h10);
        check(irq_o == 0, "R6", "irq after clear-bit write", irq_o, 0);
        check(exp_q.size() == 0, "R10", "items pending after byte", exp_q.size(), 0);

        // R11 start code while held is ignored: plain byte, no START
        reg_write(1'b0, 8'hE0);
        send_byte(8'h81);
        slave_nack = 1'b1;
        wait_irq("R7");
        check(nack_o == 1, "R5", "nack latched", nack_o, 1);
        reg_write(1'b0, 8'h10);

        // R9 refused byte ended by stop; R8 dummy byte not sent
        send_stop(8'h55);
        wait_free("R9");
        repeat (4) @(negedge clk);
        check(scl_low_o == 0 && sda_low_o == 0, "R9", "lines after stop",
              {scl_low_o, sda_low_o}, 0);
        check(exp_q.size() == 0, "R8", "items pending after stop", exp_q.size(), 0);

        // Second transfer, acknowledged end
        slave_nack = 1'b0;
        send_start(8'h90);
        wait_irq("R3");
        check(nack_o == 0, "R5", "ack after address", nack_o, 0);
        reg_write(1'b0, 8'h10);
        send_byte(8'h00);
        wait_irq("R7");
        reg_write(1'b0, 8'h10);
        send_byte(8'hFF);
        wait_irq("R7");
        reg_write(1'b0, 8'h10);
        send_stop(8'hAA);
        repeat (10) @(negedge clk);
        reg_write(1'b1, 8'h77);
        wait_free("R8");
        repeat (40) @(negedge clk);
        check(scl_low_o == 0 && sda_low_o == 0, "R8", "lines released",
              {scl_low_o, sda_low_o}, 0);
        check(exp_q.size() == 0, "R10", "items pending at end", exp_q.size(), 0);
        check(irq_o == 0, "R6", "no irq from stop", irq_o, 0);
        finish_run();
    end
endmodule